// File: doc/BRIEF.md
# Prescaled down-counter timer channel

A single programmable timer channel. A counter decrements once per prescaled tick of the clock and raises an interrupt when it reaches zero. Software drives it through a plain synchronous register port. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

The counter is either 16 or 32 bits wide. In the narrow setting the upper half of the count and of the reload value are kept untouched. The channel has three behaviours:
- free-running: wrap to all-ones;
- periodic: reload from a stored value;
- single-shot: stop at zero.

Two separate write paths are provided. One loads both the reload value and the counter. The other updates only the reload value, so the change shows at the next reload.

Top module: `pdt_channel`

## Requirements
- R1: After reset, the registers read as follows:
  - mode word (offset 0x08) reads 0x20;
  - reload value (0x00 and 0x18) reads 0;
  - count (0x04) reads 0xFFFFFFFF;
  - the raw flag (0x10) and the masked flag (0x14) read 0;
  - `irq_out` is low;
  - the channel is stopped, free-running and 16-bit.
- R2: The mode word at 0x08 holds the following fields:
  - bit 7 run;
  - bit 6 periodic (0 = free-running);
  - bit 5 interrupt enable;
  - bits 3:2 prescale code;
  - bit 1 wide (1 = 32-bit);
  - bit 0 single-shot.

  Every other bit is ignored on write and reads as 0.
- R3: Prescale codes 0, 1 and 2 decrement the counter every 1, 16 and 256 clocks. Code 3 acts as code 2. A write to 0x00 or 0x08 restarts the divider, so the first decrement comes a full prescaled period after that write edge.
- R4: A write to 0x00 sets the reload value and copies all 32 written bits into the count. A write to 0x18 sets only the reload value and leaves the count alone. Offsets 0x00 and 0x18 both read back the reload value.
- R5: In free-running mode a tick at a count of zero wraps the count to all-ones of the current width (0xFFFF or 0xFFFFFFFF). The reload value is not used.
- R6: In periodic mode a tick at a count of zero reloads the count from the reload value (its low 16 bits in 16-bit mode).
- R7: In 16-bit mode only bits 15:0 of the count change. Bits 31:16 of count and reload value stay as they were and read back unchanged. Changing the width keeps them.
- R8: The interrupt flags and output behave as follows:
  - a decrement from 1 to 0 sets a sticky raw flag, read at 0x10 bit 0;
  - any write to 0x0C clears the raw flag;
  - a set in the same cycle as a clear wins;
  - 0x14 bit 0 and `irq_out` equal the raw flag ANDed with the interrupt enable.
- R9: In single-shot mode the count holds at zero after its first expiry and raises no further interrupt.
- R10: In periodic mode, writing 0 (width-masked) to 0x00 stops counting. Writing a nonzero value restarts a channel that had stopped, including an expired single-shot.
- R11: A write to 0x08 with the run bit set restarts counting even if run was already set, so an expired single-shot resumes once its mode changes.
- R12: While run is clear the count is frozen. Writes to 0x04 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (5) | Byte offset of the register, word aligned |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Masked interrupt |

## Verification
The bench counts decrements against the exact edge where a mode or reload write restarts the divider:
- an off-by-one in the divider phase shifts every count by one;
- treating prescale code 3 as code 1 is clearly off after 256 clocks.

The 16-bit tests place a nonzero upper half in the reload value and then switch widths. A design that lets the borrow or the reload spill into bits 31:16 shows a corrupted top half. A design that wraps to the wrong width returns 0x0000FFFF where 0xFFFFFFFF belongs.

The single-shot and zero-reload cases wait long after expiry to check that nothing moves or re-raises the flag. They then check that a nonzero reload or a mode write with run set brings counting back. A background reload that wrongly touches the count is visible in the very next sample.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

   // word index of each register (byte offset >> 2)
   typedef enum logic [2:0] {
      W_RELOAD = 3'd0,
      W_COUNT  = 3'd1,
      W_MODE   = 3'd2,
      W_ACK    = 3'd3,
      W_RAW    = 3'd4,
      W_MASKED = 3'd5,
      W_SHADOW = 3'd6,
      W_NONE   = 3'd7
   } word_e;

   // bit positions inside the mode word
   localparam int unsigned MB_SINGLE   = 0;
   localparam int unsigned MB_WIDE     = 1;
   localparam int unsigned MB_PRE_LO   = 2;
   localparam int unsigned MB_IRQ_EN   = 5;
   localparam int unsigned MB_PERIODIC = 6;
   localparam int unsigned MB_RUN      = 7;
   localparam int unsigned MODE_BITS   = 8;

   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       irq_en;
      logic [1:0] pre;
      logic       wide;
      logic       single;
   } mode_t;

   localparam mode_t MODE_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                    pre: 2'd0, wide: 1'b0, single: 1'b0};

   function automatic mode_t mode_unpack(input logic [MODE_BITS-1:0] w);
      mode_t m;
      m.run      = w[MB_RUN];
      m.periodic = w[MB_PERIODIC];
      m.irq_en   = w[MB_IRQ_EN];
      m.pre      = w[MB_PRE_LO +: 2];
      m.wide     = w[MB_WIDE];
      m.single   = w[MB_SINGLE];
      return m;
   endfunction

   function automatic logic [MODE_BITS-1:0] mode_pack(input mode_t m);
      logic [MODE_BITS-1:0] w;
      w                 = '0;
      w[MB_RUN]         = m.run;
      w[MB_PERIODIC]    = m.periodic;
      w[MB_IRQ_EN]      = m.irq_en;
      w[MB_PRE_LO +: 2] = m.pre;
      w[MB_WIDE]        = m.wide;
      w[MB_SINGLE]      = m.single;
      return w;
   endfunction

endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
   parameter int unsigned MID_LOG2  = 4,
   parameter int unsigned SLOW_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic [1:0] code_i,
   output logic       tick_o
);

   localparam int unsigned DIV_W  = SLOW_LOG2;
   localparam int unsigned NCODES = 4;

   if (MID_LOG2 < 1) begin : g_bad_mid
      $error("pdt_prescaler: MID_LOG2 must be at least 1");
   end
   if (SLOW_LOG2 <= MID_LOG2) begin : g_bad_slow
      $error("pdt_prescaler: SLOW_LOG2 must exceed MID_LOG2");
   end

   logic [DIV_W-1:0]  div_q;
   logic [NCODES-1:0] taps;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) div_q <= '0;
      else                   div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
   end

   // one tap per prescale code; the undefined top code shares the slowest tap
   for (genvar c = 0; c < NCODES; c++) begin : g_tap
      if (c == 0) begin : g_fast
         assign taps[c] = 1'b1;
      end else if (c == 1) begin : g_mid
         assign taps[c] = &div_q[MID_LOG2-1:0];
      end else begin : g_slow
         assign taps[c] = &div_q;
      end
   end

   assign tick_o = taps[code_i];

   // R3: a divided tick never repeats on consecutive cycles
   a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i != 2'd0 && tick_o && !clear_i) |=> !tick_o);

endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             periodic_i,
   input  logic             wide_i,
   input  logic             single_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             ld_wr_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic             mode_wr_i,
   input  logic             rearm_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_evt_o
);

   localparam int unsigned HALF_W = CNT_W / 2;
   localparam int unsigned LANES  = 2;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W % 2 != 0 || CNT_W < 8) begin : g_bad_width
      $error("pdt_counter: CNT_W must be even and at least 8");
   end

   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] active;
   logic [CNT_W-1:0] nxt_full;
   logic [CNT_W-1:0] wrap_val;
   logic             at_zero, at_one, step, ld_zero;
   logic             halted_q;

   always_comb begin
      active   = wide_i ? cnt_w : {{HALF_W{1'b0}}, cnt_w[HALF_W-1:0]};
      at_zero  = (active == '0);
      at_one   = (active == ONE);
      wrap_val = periodic_i ? reload_i : '1;
      nxt_full = at_zero ? wrap_val : (cnt_w - ONE);
      ld_zero  = wide_i ? (ld_val_i == '0) : (ld_val_i[HALF_W-1:0] == '0);
      // register writes take the cycle; no decrement alongside them
      step     = tick_i && run_i && !halted_q && !ld_wr_i && !mode_wr_i;
   end

   assign zero_evt_o = step && at_one;

   // low lane always counts, high lane only in wide mode
   for (genvar h = 0; h < LANES; h++) begin : g_lane
      logic              lane_live;
      logic [HALF_W-1:0] lane_q;
      if (h == 0) begin : g_low
         assign lane_live = 1'b1;
      end else begin : g_high
         assign lane_live = wide_i;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)                 lane_q <= '1;
         else if (ld_wr_i)           lane_q <= ld_val_i[h*HALF_W +: HALF_W];
         else if (step && lane_live) lane_q <= nxt_full[h*HALF_W +: HALF_W];
      end
      assign cnt_w[h*HALF_W +: HALF_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     halted_q <= 1'b0;
      else if (ld_wr_i && periodic_i) halted_q <= ld_zero;
      else if (rearm_i)               halted_q <= 1'b0;
      else if (zero_evt_o && single_i) halted_q <= 1'b1;
   end

   assign cnt_o = cnt_w;

   // R7: narrow mode never disturbs the upper half
   a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_i && !ld_wr_i) |=> $stable(cnt_w[CNT_W-1:HALF_W]));

   // R12: a stopped channel keeps its count
   a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !ld_wr_i) |=> $stable(cnt_w));

   // R9: an expired single-shot or zero-loaded channel stays put
   a_r9_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !ld_wr_i && !mode_wr_i) |=> $stable(cnt_w));

   // R8: reaching zero is a one-cycle event
   a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt_o |=> !zero_evt_o);

endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
   import pdt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              zero_evt_i,
   output mode_t             mode_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic              ld_wr_o,
   output logic              mode_wr_o,
   output logic              rearm_o,
   output logic              irq_o
);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("pdt_regs: ADDR_W must be at least 5");
   end

   logic       hi_ok;
   word_e      word;
   logic       hit;
   logic       unused_addr_lsb;
   mode_t      mode_q;
   logic [CNT_W-1:0] reload_q;
   logic       raw_q, masked;
   logic       shadow_wr, ack_wr;

   if (ADDR_W > 5) begin : g_hi_decode
      assign hi_ok = ~|bus_addr[ADDR_W-1:5];
   end else begin : g_no_hi
      assign hi_ok = 1'b1;
   end

   assign unused_addr_lsb = ^bus_addr[1:0];
   assign word      = word_e'(bus_addr[4:2]);
   assign hit       = bus_wr && hi_ok;
   assign ld_wr_o   = hit && (word == W_RELOAD);
   assign shadow_wr = hit && (word == W_SHADOW);
   assign mode_wr_o = hit && (word == W_MODE);
   assign ack_wr    = hit && (word == W_ACK);
   assign rearm_o   = mode_wr_o && bus_wdata[MB_RUN];

   always_ff @(posedge clk) begin
      if (!rst_n)         mode_q <= MODE_RESET;
      else if (mode_wr_o) mode_q <= mode_unpack(bus_wdata[MODE_BITS-1:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     reload_q <= '0;
      else if (ld_wr_o || shadow_wr)  reload_q <= bus_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          raw_q <= 1'b0;
      else if (zero_evt_i) raw_q <= 1'b1;
      else if (ack_wr)     raw_q <= 1'b0;
   end

   assign masked = raw_q && mode_q.irq_en;

   always_comb begin
      bus_rdata = '0;
      if (hi_ok) begin
         unique case (word)
            W_RELOAD, W_SHADOW: bus_rdata = reload_q;
            W_COUNT:            bus_rdata = cnt_i;
            W_MODE:             bus_rdata = {{(CNT_W-MODE_BITS){1'b0}}, mode_pack(mode_q)};
            W_RAW:              bus_rdata = {{(CNT_W-1){1'b0}}, raw_q};
            W_MASKED:           bus_rdata = {{(CNT_W-1){1'b0}}, masked};
            default:            bus_rdata = '0;
         endcase
      end
   end

   assign mode_o   = mode_q;
   assign reload_o = reload_q;
   assign irq_o    = masked;

   // R8: the raw flag is sticky until acknowledged
   a_r8_raw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q && !ack_wr) |=> raw_q);

   // R8: the raw flag only rises after the counter reached zero
   a_r8_raw_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q) |-> $past(zero_evt_i));

endmodule

// File: rtl/pdt_channel.sv
module pdt_channel
   import pdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned MID_LOG2  = 4,
   parameter int unsigned SLOW_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq_out
);

   mode_t            mode;
   logic [CNT_W-1:0] reload, cnt;
   logic             ld_wr, mode_wr, rearm, zero_evt, tick;

   pdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt_i      (cnt),
      .zero_evt_i (zero_evt),
      .mode_o     (mode),
      .reload_o   (reload),
      .ld_wr_o    (ld_wr),
      .mode_wr_o  (mode_wr),
      .rearm_o    (rearm),
      .irq_o      (irq_out)
   );

   pdt_prescaler #(.MID_LOG2(MID_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (ld_wr || mode_wr),
      .code_i  (mode.pre),
      .tick_o  (tick)
   );

   pdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .run_i      (mode.run),
      .periodic_i (mode.periodic),
      .wide_i     (mode.wide),
      .single_i   (mode.single),
      .reload_i   (reload),
      .ld_wr_i    (ld_wr),
      .ld_val_i   (bus_wdata),
      .mode_wr_i  (mode_wr),
      .rearm_i    (rearm),
      .cnt_o      (cnt),
      .zero_evt_o (zero_evt)
   );

endmodule

// File: tb/sim_pdt_channel.sv
module sim_pdt_channel;

   localparam int CLK_PERIOD = 20;
   localparam logic [4:0] O_RLD = 5'h00, O_CNT = 5'h04, O_MODE = 5'h08,
                          O_ACK = 5'h0C, O_RAW = 5'h10, O_MSK = 5'h14,
                          O_SHD = 5'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;
   int          n_vec = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pdt_channel u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   // called just after a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic irq_chk(input string tag, input logic exp);
      #1;
      chk(tag, {31'b0, irq_out}, {31'b0, exp});
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk("R1 mode word", O_MODE, 32'h20);
      rd_chk("R1 reload", O_RLD, 32'h0);
      rd_chk("R1 count", O_CNT, 32'hFFFF_FFFF);
      rd_chk("R1 raw flag", O_RAW, 32'h0);
      rd_chk("R1 masked flag", O_MSK, 32'h0);
      irq_chk("R1 irq", 1'b0);
   endtask

   task automatic t_free16;
      wr(O_MODE, 32'hA0);
      wr(O_RLD, 32'h0003_0005);
      wait_clks(2);
      rd_chk("R4 load copies count", O_CNT, 32'h0003_0003);
      wait_clks(3);
      rd_chk("R7 narrow count at zero", O_CNT, 32'h0003_0000);
      rd_chk("R8 raw set", O_RAW, 32'h1);
      rd_chk("R8 masked set", O_MSK, 32'h1);
      irq_chk("R8 irq high", 1'b1);
      wait_clks(1);
      rd_chk("R5 16-bit wrap", O_CNT, 32'h0003_FFFF);
      rd_chk("R4 reload readback", O_RLD, 32'h0003_0005);
      rd_chk("R4 shadow readback", O_SHD, 32'h0003_0005);
   endtask

   task automatic t_ack;
      wr(O_ACK, 32'h0);
      rd_chk("R8 raw cleared", O_RAW, 32'h0);
      irq_chk("R8 irq low after clear", 1'b0);
   endtask

   task automatic t_periodic;
      wr(O_MODE, 32'hC2);
      wr(O_RLD, 32'h3);
      wait_clks(3);
      rd_chk("R6 count zero", O_CNT, 32'h0);
      rd_chk("R8 raw set unmasked", O_RAW, 32'h1);
      rd_chk("R8 masked off", O_MSK, 32'h0);
      irq_chk("R8 irq masked", 1'b0);
      wait_clks(1);
      rd_chk("R6 reload", O_CNT, 32'h3);
      wr(O_SHD, 32'h5);
      rd_chk("R4 shadow keeps count", O_CNT, 32'h2);
      wait_clks(2);
      rd_chk("R6 count zero again", O_CNT, 32'h0);
      wait_clks(1);
      rd_chk("R4 shadow used at reload", O_CNT, 32'h5);
      rd_chk("R4 reload reads shadow", O_RLD, 32'h5);
      wr(O_ACK, 32'h0);
   endtask

   task automatic t_prescale;
      wr(O_MODE, 32'hC6);
      wr(O_RLD, 32'd100);
      wait_clks(15);
      rd_chk("R3 div16 before tick", O_CNT, 32'd100);
      wait_clks(1);
      rd_chk("R3 div16 first tick", O_CNT, 32'd99);
      wait_clks(32);
      rd_chk("R3 div16 rate", O_CNT, 32'd97);
      wr(O_MODE, 32'hCE);
      wr(O_RLD, 32'd50);
      wait_clks(255);
      rd_chk("R3 code3 before tick", O_CNT, 32'd50);
      wait_clks(1);
      rd_chk("R3 code3 acts as div256", O_CNT, 32'd49);
      rd_chk("R2 mode readback", O_MODE, 32'hCE);
   endtask

   task automatic t_single;
      wr(O_ACK, 32'h0);
      wr(O_MODE, 32'hC3);
      wr(O_RLD, 32'h2);
      wait_clks(2);
      rd_chk("R9 single expiry", O_CNT, 32'h0);
      rd_chk("R9 single raw", O_RAW, 32'h1);
      wr(O_ACK, 32'h0);
      wait_clks(5);
      rd_chk("R9 held at zero", O_CNT, 32'h0);
      rd_chk("R9 no new interrupt", O_RAW, 32'h0);
      wr(O_RLD, 32'h4);
      wait_clks(4);
      rd_chk("R10 restart by load", O_CNT, 32'h0);
      rd_chk("R10 restart raw", O_RAW, 32'h1);
      wr(O_ACK, 32'h0);
      wr(O_MODE, 32'hC2);
      wait_clks(1);
      rd_chk("R11 mode write restarts", O_CNT, 32'h4);
      wait_clks(1);
      rd_chk("R11 keeps counting", O_CNT, 32'h3);
   endtask

   task automatic t_zero_load;
      wr(O_ACK, 32'h0);
      wr(O_RLD, 32'h0);
      wait_clks(10);
      rd_chk("R10 zero load stops", O_CNT, 32'h0);
      rd_chk("R10 zero load no irq", O_RAW, 32'h0);
      wr(O_RLD, 32'h10);
      wait_clks(1);
      rd_chk("R10 nonzero load resumes", O_CNT, 32'hF);
   endtask

   task automatic t_freeze;
      wr(O_MODE, 32'h42);
      wait_clks(10);
      rd_chk("R12 frozen", O_CNT, 32'hF);
      wr(O_CNT, 32'h1234);
      rd_chk("R12 count write ignored", O_CNT, 32'hF);
      wr(O_MODE, 32'hFFFF_FF50);
      rd_chk("R2 reserved bits zero", O_MODE, 32'h40);
   endtask

   task automatic t_width;
      wr(O_MODE, 32'h42);
      wr(O_RLD, 32'hABCD_0003);
      wr(O_MODE, 32'hC0);
      wait_clks(3);
      rd_chk("R7 narrow zero keeps top", O_CNT, 32'hABCD_0000);
      wait_clks(1);
      rd_chk("R7 narrow reload keeps top", O_CNT, 32'hABCD_0003);
      wr(O_MODE, 32'h40);
      wr(O_MODE, 32'h42);
      rd_chk("R7 widen keeps count", O_CNT, 32'hABCD_0003);
      rd_chk("R7 widen keeps reload", O_RLD, 32'hABCD_0003);
      wr(O_ACK, 32'h0);
      wr(O_MODE, 32'h82);
      wr(O_RLD, 32'h1);
      wait_clks(1);
      rd_chk("R5 wide zero", O_CNT, 32'h0);
      wait_clks(1);
      rd_chk("R5 32-bit wrap", O_CNT, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_free16();
      t_ack();
      t_periodic();
      t_prescale();
      t_single();
      t_zero_load();
      t_freeze();
      t_width();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule